// File: doc/BRIEF.md
# Johnson-Counter Timing Pulse Generator

This block drives a bank of control strobes so that exactly one strobe is high in each clock period. The active strobe steps along the bank on every rising clock edge, so the downstream units that it drives are started one after another in a fixed order. After the last strobe the bank wraps round to the first one and the pattern repeats.

The sequencer is a twisted-ring shift register of `STAGES` flops. The first flop loads the inverse of the last flop, and every other flop loads the flop before it. This ring passes through `2*STAGES` distinct states. Each strobe is decoded from its state by one two-input AND of adjacent stages, so a single gate level lies between the flops and every strobe. The raw stage vector is also brought out.

A synchronous, active-high reset clears every stage. Strobe 0 is therefore the first strobe active after reset. States that the ring cannot reach from reset are not repaired by the logic, and only reset clears them. `STAGES` must be at least 2. The default is 3, which gives six strobes.

Top module: `jc_pulse_gen`

## Requirements
- R1: On a rising edge with `rst` high, every stage is cleared, so `stage_o` reads all zeros and `strobe_o` reads with only bit 0 set.
- R2: Reset takes priority over shifting: while `rst` stays high over several edges, `stage_o` stays all zeros and strobe 0 stays active.
- R3: On each rising edge with `rst` low, `stage_o[0]` takes the inverse of the old `stage_o[STAGES-1]`, and `stage_o[k]` (k ≥ 1) takes the old `stage_o[k-1]`.
- R4: Starting from reset, the stage vector repeats with a period of `2*STAGES` edges. For the default of 3, written as `stage_o` values, the order is 000, 001, 011, 111, 110, 100 and then back to 000.
- R5: In every cycle reached from reset, exactly one bit of `strobe_o` is high.
- R6: The active strobe index goes from k to (k+1) mod `2*STAGES` on each edge with `rst` low, and the index equals the number of edges since reset was released, mod `2*STAGES`.
- R7: For k < `STAGES`, `strobe_o[k]` = p & ~`stage_o[k]`, and `strobe_o[STAGES+k]` = ~p & `stage_o[k]`. Here p is `stage_o[k-1]`, except for k = 0, where p is ~`stage_o[STAGES-1]`. In particular, strobe 0 is high exactly when all stages are 0, and strobe `STAGES` is high exactly when all stages are 1.
- R8: `stage_o` presents the raw stage flops, with bit 0 being the stage that is fed from the inverted last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on the rising edge |
| rst | input | 1 | Synchronous reset, active high, has priority over shifting |
| strobe_o | output | 2*STAGES | One-hot control strobes, bit k active in phase k |
| stage_o | output | STAGES | Raw twisted-ring stage values |

## Verification
The bound checker watches four behaviours on every cycle. It checks that reset clears the stages, that each clock applies the shift-with-inversion step, that the strobe bank holds exactly one high bit and rotates left by one position per clock, and that the end strobes match the all-zero and all-one states. The full period and the literal six-state order for the default width can only be shown by the bench's scenarios. The same holds for the restart at strobe 0 after a reset pulse of random length placed at a random point in the cycle, for a long reset hold, and for the decode of every middle strobe against the rule.

// File: rtl/jc_pkg.sv
package jc_pkg;
  // Number of strobe phases produced by a twisted ring of the given length.
  function automatic int unsigned phase_count(input int unsigned stages);
    return 2 * stages;
  endfunction
endpackage

// File: rtl/jc_twisted_ring.sv
module jc_twisted_ring #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STAGES-1:0] ring_q
);
  logic [STAGES-1:0] ring_d;

  // Inverted tail feeds the head; every other stage copies its neighbour.
  always_comb begin
    ring_d[0] = ~ring_q[STAGES-1];
    for (int unsigned k = 1; k < STAGES; k++) begin
      ring_d[k] = ring_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ring_q <= '0;
    else     ring_q <= ring_d;
  end
endmodule

// File: rtl/jc_strobe_decode.sv
module jc_strobe_decode #(
  parameter int unsigned STAGES = 3,
  localparam int unsigned PHASES = jc_pkg::phase_count(STAGES)
) (
  input  logic [STAGES-1:0] ring_q,
  output logic [PHASES-1:0] strobe
);
  for (genvar k = 0; k < STAGES; k++) begin : g_pair
    logic lead;
    if (k == 0) begin : g_head
      assign lead = ~ring_q[STAGES-1];
    end else begin : g_body
      assign lead = ring_q[k-1];
    end
    // Rising front of the ones pattern, then its complement.
    assign strobe[k]        = lead & ~ring_q[k];
    assign strobe[STAGES+k] = ~lead & ring_q[k];
  end
endmodule

// File: rtl/jc_pulse_gen.sv
module jc_pulse_gen #(
  parameter int unsigned STAGES = 3,
  localparam int unsigned PHASES = jc_pkg::phase_count(STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PHASES-1:0] strobe_o,
  output logic [STAGES-1:0] stage_o
);
  logic [STAGES-1:0] ring_q;

  jc_twisted_ring #(.STAGES(STAGES)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .ring_q (ring_q)
  );

  jc_strobe_decode #(.STAGES(STAGES)) u_dec (
    .ring_q (ring_q),
    .strobe (strobe_o)
  );

  assign stage_o = ring_q;
endmodule

// File: rtl/jc_pulse_gen_chk.sv
module jc_pulse_gen_chk #(
  parameter int unsigned STAGES = 3,
  localparam int unsigned PHASES = 2 * STAGES
) (
  input logic              clk,
  input logic              rst,
  input logic [PHASES-1:0] strobe_o,
  input logic [STAGES-1:0] stage_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (stage_o == '0) && (strobe_o == PHASES'(1)));

  p_reset_hold_r2: assert property (@(posedge clk)
    rst && $past(rst) |-> $stable(stage_o) || (stage_o == '0));

  p_shift_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rst || (stage_o == {$past(stage_o[STAGES-2:0]), ~$past(stage_o[STAGES-1])}));

  p_one_hot_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe_o) == 1);

  p_rotate_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rst || (strobe_o == {$past(strobe_o[PHASES-2:0]), $past(strobe_o[PHASES-1])}));

  p_end_strobes_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe_o[0] == (stage_o == '0)) && (strobe_o[STAGES] == (stage_o == '1)));
endmodule

bind jc_pulse_gen jc_pulse_gen_chk #(.STAGES(STAGES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .strobe_o (strobe_o),
  .stage_o  (stage_o)
);

// File: tb/tb_jc_pulse_gen.sv
`timescale 1ns/1ps
module tb_jc_pulse_gen;
  localparam int unsigned STAGES = 3;
  localparam int unsigned PHASES = 2 * STAGES;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [PHASES-1:0] strobe_o;
  logic [STAGES-1:0] stage_o;

  int unsigned nchk = 0;
  int unsigned nerr = 0;
  int unsigned exp_idx = 0;
  logic [STAGES-1:0] prev_stage;
  bit done = 0;

  always #2.5 clk = ~clk;

  jc_pulse_gen #(.STAGES(STAGES)) dut (
    .clk(clk), .rst(rst), .strobe_o(strobe_o), .stage_o(stage_o)
  );

  // Stage pattern for phase index: ones fill from bit 0, then drain from bit 0.
  function automatic logic [STAGES-1:0] stage_for(input int unsigned idx);
    logic [STAGES-1:0] v = '0;
    for (int unsigned b = 0; b < STAGES; b++) begin
      if (idx < STAGES) v[b] = (b < idx);
      else              v[b] = (b >= idx - STAGES);
    end
    return v;
  endfunction

  // Strobe bank from the decode rule applied to a stage vector.
  function automatic logic [PHASES-1:0] decode_rule(input logic [STAGES-1:0] s);
    logic [PHASES-1:0] t;
    for (int unsigned k = 0; k < STAGES; k++) begin
      logic p;
      p = (k == 0) ? ~s[STAGES-1] : s[k-1];
      t[k]        = p & ~s[k];
      t[STAGES+k] = ~p & s[k];
    end
    return t;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // Drive at negedge, let one edge pass, update model, sample 1 ns later.
  task automatic tick(input bit r);
    @(negedge clk);
    rst = r;
    prev_stage = stage_o;
    @(posedge clk);
    if (r) exp_idx = 0;
    else   exp_idx = (exp_idx + 1) % PHASES;
    #1;
    check(stage_o == stage_for(exp_idx), r ? "R1 stage" : "R4 stage sequence",
          32'(stage_o), 32'(stage_for(exp_idx)));
    check(strobe_o == (PHASES'(1) << exp_idx), "R6 active strobe",
          32'(strobe_o), 32'(PHASES'(1) << exp_idx));
    check($countones(strobe_o) == 1, "R5 one-hot", 32'($countones(strobe_o)), 32'd1);
    check(strobe_o == decode_rule(stage_o), "R7 decode", 32'(strobe_o), 32'(decode_rule(stage_o)));
    if (!r)
      check(stage_o == {prev_stage[STAGES-2:0], ~prev_stage[STAGES-1]}, "R3 shift step",
            32'(stage_o), 32'({prev_stage[STAGES-2:0], ~prev_stage[STAGES-1]}));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : stim
    logic [STAGES-1:0] lit [PHASES];
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd7531);
    lit[0] = 3'b000; lit[1] = 3'b001; lit[2] = 3'b011;
    lit[3] = 3'b111; lit[4] = 3'b110; lit[5] = 3'b100;

    // R1, R2: long reset hold keeps the ring cleared.
    for (int i = 0; i < 4; i++) begin
      tick(1'b1);
      check(stage_o == '0 && strobe_o == PHASES'(1), "R2 reset hold", 32'(stage_o), 32'd0);
    end

    // R4, R8: literal order for the default width over three periods.
    for (int i = 1; i <= 3 * PHASES; i++) begin
      tick(1'b0);
      check(stage_o == lit[i % PHASES], "R8 R4 literal order",
            32'(stage_o), 32'(lit[i % PHASES]));
    end

    // R6 wrap: one more period back to strobe 0.
    for (int i = 0; i < PHASES; i++) tick(1'b0);
    check(strobe_o[0] == 1'b1, "R6 wrap to strobe 0", 32'(strobe_o), 32'd1);

    // Random run lengths with reset pulses at random phases.
    for (int seg = 0; seg < 60; seg++) begin
      int unsigned run = 1 + ($urandom % 17);
      int unsigned rlen = 1 + ($urandom % 3);
      for (int i = 0; i < int'(run); i++) tick(1'b0);
      for (int i = 0; i < int'(rlen); i++) tick(1'b1);
      check(strobe_o == PHASES'(1), "R1 reset mid-cycle", 32'(strobe_o), 32'd1);
    end
    for (int i = 0; i < 2 * PHASES; i++) tick(1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule